// File: doc/BRIEF.md
# Multichannel DMA Controller

This block moves words between peripherals and a shared memory without the processor copying them. Software sets up each channel with a start address, a word count, a direction and a transfer mode, then starts it. The channel waits for its peripheral to raise its request line. The controller then asks the processor for the memory bus, waits for the grant, and runs the word beats. When the channel's count reaches zero, the controller releases the bus and flags completion on a sticky per-channel status bit, which drives the interrupt output.

There are two transfer modes, chosen per channel. In burst mode the bus is held from the first word to the last. In cycle-stealing mode the bus is handed back after every word, so each further word needs a fresh request/grant exchange. When several channels are pending, the lowest-numbered one is chosen. Once a channel owns the bus, no other channel can take it until that channel lets go.

The memory side is a valid/ready stream. `mem_valid` rises only while the bus is granted. Once raised, it stays high, with `mem_addr`, `mem_we` and `mem_wdata` held steady, until the memory answers with `mem_ready`. A word counts as moved only on a cycle where both are high, so memory back-pressure stalls the controller for any number of cycles without losing or repeating a word. The peripheral side is plain. Write data is taken from `per_din` on the beat. Read data appears on `per_dout` in the same cycle as the channel's `per_ack` pulse.

Top module: `mcdma_ctrl`

## Requirements
- R1: No memory beat takes place unless both `bus_req` and `bus_gnt` are high. After reset, `bus_req`, `mem_valid`, `per_ack`, `done` and `irq` are all low.
- R2: Beat k of a channel (counting from 0) uses the address programmed at register select 0, plus k, modulo 2^AW.
- R3: A started channel with count N performs exactly N beats. The last beat drops `bus_req` in the next cycle, and the channel makes no further beats even if its peripheral keeps requesting.
- R4: Control bit 1 sets the direction. With 0, each beat is a memory read (`mem_we`=0) and its data is presented on `per_dout`. With 1, each beat is a memory write (`mem_we`=1) of `per_din`. Each beat pulses the `per_ack` bit of the channel being served, and only that bit.
- R5: With control bit 2 set (burst), the whole block moves under one bus request, which stays high between beats.
- R6: With control bit 2 clear (cycle stealing), `bus_req` drops after every beat. The controller then waits for `bus_gnt` to fall before re-arbitrating, so N words take N request/grant exchanges.
- R7: While `mem_valid` is high and `mem_ready` is low, the next cycle keeps `mem_valid` high with the same address and direction. Address and count advance only on completed beats.
- R8: A channel's `done` bit is set by its completion and stays set until a register write to that channel at select 3 with data bit 0 set. `irq` is the OR of all `done` bits. Completion clears the channel's enable.
- R9: Writing control bit 0 (start) while the count register is zero raises no bus request and sets `done` at the write's clock edge.
- R10: Among pending channels, the lowest index wins arbitration. A burst, once granted, is not interrupted by a newly pending lower-index channel.
- R11: Writes to the address, count or control register of a channel that is enabled (started but not finished) are ignored.
- R12: The register address is {channel, select}, where select occupies the low 2 bits: 0 = address, 1 = count, 2 = control (bit 0 start, bit 1 direction, bit 2 burst), 3 = status clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | CHW+2 | {channel, select} |
| cfg_wdata | input | DW | Register write data |
| bus_req | output | 1 | Bus request to the processor |
| bus_gnt | input | 1 | Bus grant from the processor |
| mem_valid | output | 1 | Memory beat valid |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with mem_ready |
| per_req | input | NCH | Per-channel peripheral request |
| per_ack | output | NCH | Per-channel beat acknowledge |
| per_din | input | DW | Data from the peripheral being served |
| per_dout | output | DW | Data to the peripheral being served |
| done | output | NCH | Sticky per-channel completion |
| irq | output | 1 | Completion interrupt |

## Verification
A sweep covers both channels, counts 0 to 4, both directions, both modes, and two bus environments: one with zero grant latency and a memory that is always ready, and one with a slower grant and a ready that stalls every third cycle. Together these separate the burst and cycle-stealing handshake counts, expose off-by-one errors in the count and the address wrap near the top of the address space, and show that stalled beats are neither skipped nor repeated. Directed runs then raise two peripheral requests in the same cycle to check the fixed order. They raise a lower-index request in the middle of a stalled burst to show that the burst is not cut short. Finally, they rewrite a started but idle channel's registers to show those writes have no effect.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_REQ  = 2'd1,
    SEQ_XFER = 2'd2,
    SEQ_REL  = 2'd3
  } seq_state_e;

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_CNT  = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;
  localparam logic [1:0] SEL_CLR  = 2'd3;

  localparam int CB_GO    = 0;
  localparam int CB_TOMEM = 1;
  localparam int CB_BURST = 2;

  typedef struct packed {
    logic tomem;
    logic burst;
  } chan_mode_t;
endpackage

// File: rtl/chan_regs.sv
module chan_regs
  import dmac_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          beat,
  output logic [AW-1:0] addr,
  output logic          active,
  output chan_mode_t    mode,
  output logic          last,
  output logic          done
);
  logic [CW-1:0] cnt;
  logic          unused_wdata;

  assign unused_wdata = ^wr_data;
  assign last = (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr   <= '0;
      cnt    <= '0;
      active <= 1'b0;
      mode   <= '0;
      done   <= 1'b0;
    end else begin
      // clear first so that a completion in the same cycle wins
      if (wr_en && wr_sel == SEL_CLR && wr_data[0]) done <= 1'b0;
      if (beat) begin
        addr <= addr + 1'b1;
        cnt  <= cnt - 1'b1;
        if (last) begin
          active <= 1'b0;
          done   <= 1'b1;
        end
      end else if (wr_en && !active) begin
        case (wr_sel)
          SEL_ADDR: addr <= AW'(wr_data);
          SEL_CNT:  cnt  <= CW'(wr_data);
          SEL_CTRL: begin
            if (wr_data[CB_GO]) begin
              mode <= '{tomem: wr_data[CB_TOMEM], burst: wr_data[CB_BURST]};
              if (cnt == '0) done   <= 1'b1;
              else           active <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int N  = 2,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
  assign any = |req;
endmodule

// File: rtl/dmac_seq.sv
module dmac_seq
  import dmac_pkg::*;
#(
  parameter int IW = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          any_pend,
  input  logic [IW-1:0] pick_idx,
  input  logic          bus_gnt,
  input  logic          mem_ready,
  input  logic          cur_burst,
  input  logic          cur_last,
  output logic          bus_req,
  output logic          mem_valid,
  output logic [IW-1:0] cur_idx,
  output logic          beat
);
  seq_state_e state;

  assign bus_req   = (state == SEQ_REQ) || (state == SEQ_XFER);
  assign mem_valid = (state == SEQ_XFER);
  assign beat      = mem_valid && mem_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= SEQ_IDLE;
      cur_idx <= '0;
    end else begin
      case (state)
        SEQ_IDLE: if (any_pend) begin
          cur_idx <= pick_idx;
          state   <= SEQ_REQ;
        end
        SEQ_REQ:  if (bus_gnt) state <= SEQ_XFER;
        SEQ_XFER: if (beat && (cur_last || !cur_burst)) state <= SEQ_REL;
        SEQ_REL:  if (!bus_gnt) state <= SEQ_IDLE;
        default:  state <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mcdma_ctrl.sv
module mcdma_ctrl
  import dmac_pkg::*;
#(
  parameter int NCH = 2,
  parameter int AW  = 16,
  parameter int DW  = 16,
  parameter int CW  = 8,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CHW+1:0]   cfg_addr,
  input  logic [DW-1:0]    cfg_wdata,
  output logic             bus_req,
  input  logic             bus_gnt,
  output logic             mem_valid,
  input  logic             mem_ready,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata,
  input  logic [NCH-1:0]   per_req,
  output logic [NCH-1:0]   per_ack,
  input  logic [DW-1:0]    per_din,
  output logic [DW-1:0]    per_dout,
  output logic [NCH-1:0]   done,
  output logic             irq
);
  logic [CHW-1:0] cfg_ch;
  logic [1:0]     cfg_sel;
  logic [AW-1:0]  ch_addr [NCH];
  chan_mode_t     ch_mode [NCH];
  logic [NCH-1:0] ch_active;
  logic [NCH-1:0] ch_last;
  logic [NCH-1:0] pend;
  logic [CHW-1:0] pick_idx;
  logic [CHW-1:0] cur_idx;
  logic           any_pend;
  logic           beat;
  logic           cur_burst;
  logic           cur_last;

  assign cfg_ch  = cfg_addr[CHW+1:2];
  assign cfg_sel = cfg_addr[1:0];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    chan_regs #(.AW(AW), .DW(DW), .CW(CW)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (cfg_we && cfg_ch == CHW'(g)),
      .wr_sel (cfg_sel),
      .wr_data(cfg_wdata),
      .beat   (beat && cur_idx == CHW'(g)),
      .addr   (ch_addr[g]),
      .active (ch_active[g]),
      .mode   (ch_mode[g]),
      .last   (ch_last[g]),
      .done   (done[g])
    );
  end

  assign pend = ch_active & per_req;

  prio_pick #(.N(NCH), .IW(CHW)) u_pick (
    .req(pend),
    .idx(pick_idx),
    .any(any_pend)
  );

  assign cur_burst = ch_mode[cur_idx].burst;
  assign cur_last  = ch_last[cur_idx];

  dmac_seq #(.IW(CHW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .any_pend (any_pend),
    .pick_idx (pick_idx),
    .bus_gnt  (bus_gnt),
    .mem_ready(mem_ready),
    .cur_burst(cur_burst),
    .cur_last (cur_last),
    .bus_req  (bus_req),
    .mem_valid(mem_valid),
    .cur_idx  (cur_idx),
    .beat     (beat)
  );

  assign mem_addr  = ch_addr[cur_idx];
  assign mem_we    = ch_mode[cur_idx].tomem;
  assign mem_wdata = per_din;
  assign per_dout  = mem_rdata;
  assign per_ack   = beat ? (NCH'(1) << cur_idx) : '0;
  assign irq       = |done;
endmodule

// File: rtl/dmac_chk.sv
module dmac_chk #(
  parameter int NCH = 2,
  parameter int AW  = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cfg_we,
  input logic [1:0]     cfg_sel,
  input logic           bus_req,
  input logic           bus_gnt,
  input logic           mem_valid,
  input logic           mem_ready,
  input logic           mem_we,
  input logic [AW-1:0]  mem_addr,
  input logic [NCH-1:0] per_ack,
  input logic           cur_burst,
  input logic           cur_last,
  input logic           irq
);
  assert_beat_needs_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (bus_req && bus_gnt));

  assert_last_releases_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && cur_last) |=> !bus_req);

  assert_ack_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(per_ack));

  assert_ack_on_beat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (per_ack != '0) |-> (mem_valid && mem_ready));

  assert_burst_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && cur_burst && !cur_last) |=> (bus_req && mem_valid));

  assert_single_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && !cur_burst) |=> !bus_req);

  assert_valid_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we)));

  assert_irq_falls_on_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> ($past(cfg_we) && $past(cfg_sel) == 2'd3));
endmodule

bind mcdma_ctrl dmac_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_we   (cfg_we),
  .cfg_sel  (cfg_addr[1:0]),
  .bus_req  (bus_req),
  .bus_gnt  (bus_gnt),
  .mem_valid(mem_valid),
  .mem_ready(mem_ready),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .per_ack  (per_ack),
  .cur_burst(cur_burst),
  .cur_last (cur_last),
  .irq      (irq)
);

// File: tb/tb_mcdma_ctrl.sv
`timescale 1ns/1ps
module tb_mcdma_ctrl;
  localparam int NCH = 2;
  localparam int AW  = 16;
  localparam int DW  = 16;
  localparam int CW  = 8;
  localparam int CHW = 1;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           cfg_we = 1'b0;
  logic [CHW+1:0] cfg_addr = '0;
  logic [DW-1:0]  cfg_wdata = '0;
  logic           bus_req;
  logic           bus_gnt = 1'b0;
  logic           mem_valid;
  logic           mem_ready = 1'b1;
  logic           mem_we;
  logic [AW-1:0]  mem_addr;
  logic [DW-1:0]  mem_wdata;
  logic [DW-1:0]  mem_rdata;
  logic [NCH-1:0] per_req = '0;
  logic [NCH-1:0] per_ack;
  logic [DW-1:0]  per_din;
  logic [DW-1:0]  per_dout;
  logic [NCH-1:0] done;
  logic           irq;

  mcdma_ctrl #(.NCH(NCH), .AW(AW), .DW(DW), .CW(CW)) dut (.*);

  always #2 clk = ~clk;

  function automatic logic [15:0] rdf(logic [15:0] a);
    return {a[7:0] ^ 8'h5A, a[15:8]};
  endfunction
  function automatic logic [15:0] wdf(logic [15:0] a);
    return a ^ 16'hC3A1;
  endfunction

  assign mem_rdata = rdf(mem_addr);
  assign per_din   = wdf(mem_addr);

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  int gcnt = 0;
  int glat = 0;
  bit stall = 1'b0;

  // processor grant and memory ready model
  always @(posedge clk) begin
    #1;
    cyc++;
    if (bus_req) begin
      gcnt++;
      bus_gnt = (gcnt > glat);
    end else begin
      gcnt = 0;
      bus_gnt = 1'b0;
    end
    mem_ready = stall ? ((cyc % 3) != 0) : 1'b1;
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // beat log
  int lg_ch   [64];
  int lg_addr [64];
  int lg_we   [64];
  int lg_data [64];
  int lg_gnt  [64];
  int nb = 0;
  int hs = 0;
  bit req_q = 1'b0;
  bit hold_p = 1'b0;
  int hold_a = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_req && !req_q) hs++;
      req_q = bus_req;
      if (hold_p)
        check(mem_valid && int'(mem_addr) == hold_a, "R7 stalled beat held", int'(mem_addr), hold_a);
      hold_p = mem_valid && !mem_ready;
      hold_a = int'(mem_addr);
      if (mem_valid && mem_ready && nb < 64) begin
        lg_ch[nb]   = (per_ack == 2'b01) ? 0 : (per_ack == 2'b10) ? 1 : -1;
        lg_addr[nb] = int'(mem_addr);
        lg_we[nb]   = int'(mem_we);
        lg_data[nb] = mem_we ? int'(mem_wdata) : int'(per_dout);
        lg_gnt[nb]  = int'(bus_gnt);
        nb++;
      end
    end
  end

  task automatic cfg_write(input int ch, input int sel, input int data);
    @(posedge clk); #1;
    cfg_we    = 1'b1;
    cfg_addr  = {ch[0], sel[1:0]};
    cfg_wdata = 16'(data);
    @(posedge clk); #1;
    cfg_we    = 1'b0;
  endtask

  task automatic set_req(input int ch, input bit v);
    @(posedge clk); #1;
    per_req[ch] = v;
  endtask

  task automatic wait_done(input int mask, input int tmo);
    for (int i = 0; i < tmo; i++) begin
      @(negedge clk);
      if ((int'(done) & mask) == mask) break;
    end
  endtask

  task automatic clear_log();
    @(negedge clk);
    nb = 0;
    hs = 0;
  endtask

  task automatic check_beats(input int from, input int n, input int ch, input int base, input int tomem);
    for (int k = 0; k < n; k++) begin
      int a;
      a = (base + k) & 16'hFFFF;
      check(lg_addr[from+k] == a, "R2 beat address", lg_addr[from+k], a);
      check(lg_ch[from+k] == ch, "R10/R4 serving channel", lg_ch[from+k], ch);
      check(lg_we[from+k] == tomem, "R4 direction", lg_we[from+k], tomem);
      check(lg_data[from+k] == (tomem ? int'(wdf(16'(a))) : int'(rdf(16'(a)))),
            "R4 beat data", lg_data[from+k], tomem ? int'(wdf(16'(a))) : int'(rdf(16'(a))));
      check(lg_gnt[from+k] == 1, "R1 grant during beat", lg_gnt[from+k], 1);
    end
  endtask

  task automatic run_one(input int ch, input int cnt, input int burst, input int tomem, input int stl);
    int base;
    int exp_hs;
    stall = stl[0];
    glat  = stl ? 2 : 0;
    base  = tomem ? (16'hFFFE - ch) : (16'h0200 + ch * 32 + cnt);
    clear_log();
    cfg_write(ch, 0, base);
    cfg_write(ch, 1, cnt);
    set_req(ch, 1'b1);
    cfg_write(ch, 2, (burst << 2) | (tomem << 1) | 1);
    if (cnt == 0) begin
      @(negedge clk);
      check(done[ch] == 1'b1, "R9 zero count completes at once", int'(done[ch]), 1);
    end
    wait_done(1 << ch, 400);
    repeat (12) @(negedge clk);
    check(nb == cnt, "R3 beat count", nb, cnt);
    if (nb == cnt) check_beats(0, cnt, ch, base, tomem);
    exp_hs = (cnt == 0) ? 0 : (burst ? 1 : cnt);
    if (cnt == 0)   check(hs == exp_hs, "R9 no bus request", hs, exp_hs);
    else if (burst) check(hs == exp_hs, "R5 burst handshakes", hs, exp_hs);
    else            check(hs == exp_hs, "R6 cycle-steal handshakes", hs, exp_hs);
    check(irq == 1'b1, "R8 irq sticky after completion", int'(irq), 1);
    set_req(ch, 1'b0);
    cfg_write(ch, 3, 1);
    @(negedge clk);
    check(irq == 1'b0, "R8 irq cleared by status write", int'(irq), 0);
  endtask

  initial begin
    #(4 * 150000);
    n_err++;
    $display("FAIL R3 watchdog expired actual=%0d expected=%0d", cyc, 150000);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(bus_req == 1'b0,   "R1 reset bus_req", int'(bus_req), 0);
    check(mem_valid == 1'b0, "R1 reset mem_valid", int'(mem_valid), 0);
    check(per_ack == '0,     "R1 reset per_ack", int'(per_ack), 0);
    check(done == '0,        "R8 reset done", int'(done), 0);
    check(irq == 1'b0,       "R8 reset irq", int'(irq), 0);

    // sweep over channel, count, mode, direction and bus environment (R12 map)
    for (int ch = 0; ch < NCH; ch++)
      for (int cnt = 0; cnt < 5; cnt++)
        for (int b = 0; b < 2; b++)
          for (int d = 0; d < 2; d++)
            for (int s = 0; s < 2; s++)
              run_one(ch, cnt, b, d, s);

    // R10: simultaneous requests, both burst
    stall = 1'b0; glat = 0;
    clear_log();
    cfg_write(0, 0, 16'h0300); cfg_write(0, 1, 3); cfg_write(0, 2, 5);
    cfg_write(1, 0, 16'h0400); cfg_write(1, 1, 3); cfg_write(1, 2, 5);
    @(posedge clk); #1 per_req = 2'b11;
    wait_done(3, 400);
    repeat (6) @(negedge clk);
    check(nb == 6, "R10 both channels moved", nb, 6);
    if (nb == 6) begin
      check_beats(0, 3, 0, 16'h0300, 0);
      check_beats(3, 3, 1, 16'h0400, 0);
    end
    check(hs == 2, "R10 one grant per burst", hs, 2);
    @(posedge clk); #1 per_req = 2'b00;
    cfg_write(0, 3, 1); cfg_write(1, 3, 1);

    // R10: lower channel arrives mid-burst and must wait
    stall = 1'b1; glat = 1;
    clear_log();
    cfg_write(0, 0, 16'h0600); cfg_write(0, 1, 2); cfg_write(0, 2, 1);
    cfg_write(1, 0, 16'h0500); cfg_write(1, 1, 5);
    set_req(1, 1'b1);
    cfg_write(1, 2, 7);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (nb >= 1) break;
    end
    set_req(0, 1'b1);
    wait_done(3, 600);
    repeat (8) @(negedge clk);
    check(nb == 7, "R10 mid-burst total beats", nb, 7);
    if (nb == 7) begin
      check_beats(0, 5, 1, 16'h0500, 1);
      check_beats(5, 2, 0, 16'h0600, 0);
    end
    @(posedge clk); #1 per_req = 2'b00;
    cfg_write(0, 3, 1); cfg_write(1, 3, 1);

    // R11: rewrites of an enabled, idle channel are ignored
    stall = 1'b0; glat = 0;
    clear_log();
    cfg_write(0, 0, 16'h0700); cfg_write(0, 1, 4); cfg_write(0, 2, 1);
    cfg_write(0, 0, 16'h7777); cfg_write(0, 1, 9); cfg_write(0, 2, 7);
    repeat (4) @(negedge clk);
    check(hs == 0, "R11 no request without peripheral", hs, 0);
    set_req(0, 1'b1);
    wait_done(1, 400);
    repeat (10) @(negedge clk);
    check(nb == 4, "R11 count unchanged", nb, 4);
    if (nb == 4) check_beats(0, 4, 0, 16'h0700, 0);
    check(hs == 4, "R11 mode unchanged", hs, 4);
    set_req(0, 1'b0);
    cfg_write(0, 3, 1);
    @(negedge clk);
    check(irq == 1'b0, "R8 final clear", int'(irq), 0);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule